// File: doc/BRIEF.md
# Eight-Point Direct-Sum Cosine Transform Engine

This block computes the eight-point one-dimensional discrete cosine transform of a block of samples, or the inverse transform, by evaluating the defining sum term by term. A single signed multiplier and one accumulator are shared over time. A cosine-coefficient ROM supplies the weights, and a small sequencer steps through each output index and each summation index. Sixty-four multiply-accumulate steps produce one block of eight results.

A host raises the start input for one cycle to open a block and sets the mode input at the same time. It then presents eight signed samples, one on each clock in which the enable input is high. Once all eight results are held internally, the ready output goes high. The host collects the results on the output bus in ascending index order, one on each enabled clock. Ready drops after the last result has been taken, and the engine then accepts the next start.

Top module: `dct8_engine`

## Requirements
- R1: A synchronous active-high reset, applied at any time including part-way through a block, returns the engine to idle. After reset, ready is low, y is zero and no results appear until a new start is given.
- R2: Start is acted on only while the engine is idle. A start pulse during loading, computation or unloading has no effect on the block in progress.
- R3: After an accepted start, the next eight clocks with enable high each store the value on x as samples 0 to 7 in order. Cycles with enable low store nothing and do not advance the sample index.
- R4: With mode 0 (idct low at start), result k is the rounded value of sum over n of x[n]·C(k,n)/128.
- R5: With mode 1 (idct high at start), result n is the rounded value of sum over k of x[k]·C(k,n)/128. This uses the same table with the roles of the two indices exchanged.
- R6: The weight C(f,p) is round(64·c(f)·cos((2p+1)·f·π/16)), stored as an 8-bit signed value with 7 fraction bits. Here c(0)=1/√2 and c(f)=1 otherwise, which gives C(0,p)=45 and C(1,0)=63.
- R7: Each 20-bit signed sum is rounded by adding 64 and shifting right by 7 bits with sign extension. It is then clamped to the range −128 to 127.
- R8: Ready rises on the 64th clock edge after the edge that stores the eighth sample.
- R9: While ready is high, y shows result 0 first. Each clock with enable high moves y to the next index. A clock with enable low holds y and ready unchanged. The edge that consumes result 7 returns ready low.
- R10: The mode is captured on the clock that accepts start. Changes on idct later in the block do not change its results.
- R11: While ready is low, y is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Qualifies each sample load and each result unload |
| start | input | 1 | Opens a new block when the engine is idle |
| idct | input | 1 | Transform direction captured at start: 0 forward, 1 inverse |
| x | input | 8 | Signed two's-complement input sample |
| y | output | 8 | Signed result, valid while ready is high |
| ready | output | 1 | High while the eight results of a block are being unloaded |

## Verification
The properties assume that start arrives as a clean pulse from a host that waits for idle before opening a block. They also assume that enable is the only qualifier on the load and unload phases, so that the latency count and the hold-on-stall checks can read phase and ready without knowledge of the data. The stimulus opens each block only after the previous one has been drained. It inserts enable gaps during loading and unloading, and it pulses start and toggles idct only while a block is busy, which is the misuse that the ignore rules cover. The data patterns include full-scale positive and negative values, so that the clamp is reached in both directions and the 20-bit accumulator is exercised near its largest sums.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

    localparam int NPT       = 8;
    localparam int IDX_W     = $clog2(NPT);
    localparam int DATA_W    = 8;
    localparam int COEF_W    = 8;
    localparam int COEF_FRAC = 7;
    localparam int ACC_W     = 20;
    localparam int ROM_AW    = 1 + 2 * IDX_W;
    localparam int ROM_DEPTH = 1 << ROM_AW;
    localparam int MAC_STEPS = NPT * NPT;

    localparam logic signed [COEF_W-1:0] DC_COEF = 8'sd45;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOAD   = 2'd1,
        PH_MAC    = 2'd2,
        PH_UNLOAD = 2'd3
    } phase_e;

    typedef enum logic {
        MODE_FWD = 1'b0,
        MODE_INV = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e            mode;
        logic [IDX_W-1:0] out_i;
        logic [IDX_W-1:0] sum_i;
    } rom_addr_t;

    typedef struct packed {
        logic             run;
        logic             first;
        logic             last;
        logic [IDX_W-1:0] out_i;
        logic [IDX_W-1:0] sum_i;
    } mac_ctl_t;

    // Half-scaled cosine of j*pi/16 for j in 0..8, Q1.7
    function automatic logic signed [COEF_W-1:0] half_cos(input int j);
        case (j)
            0:       return 8'sd64;
            1:       return 8'sd63;
            2:       return 8'sd59;
            3:       return 8'sd53;
            4:       return 8'sd45;
            5:       return 8'sd36;
            6:       return 8'sd24;
            7:       return 8'sd12;
            default: return 8'sd0;
        endcase
    endfunction

    // Weight for output index a and summation index b; inverse swaps roles
    function automatic logic signed [COEF_W-1:0] coef_value(
        input logic             inv,
        input logic [IDX_W-1:0] a,
        input logic [IDX_W-1:0] b
    );
        int freq;
        int pos;
        int m;
        freq = inv ? int'(b) : int'(a);
        pos  = inv ? int'(a) : int'(b);
        if (freq == 0) return DC_COEF;
        m = ((2 * pos + 1) * freq) % (4 * NPT);
        if (m > 2 * NPT) m = 4 * NPT - m;
        if (m <= NPT) return half_cos(m);
        return -half_cos(2 * NPT - m);
    endfunction

    function automatic logic signed [DATA_W-1:0] sat_round(
        input logic signed [ACC_W-1:0] a
    );
        logic signed [ACC_W-1:0] r;
        r = (a + ACC_W'(1 << (COEF_FRAC - 1))) >>> COEF_FRAC;
        if (r > ACC_W'(127))  return 8'sd127;
        if (r < -ACC_W'(128)) return -8'sd128;
        return r[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/dct8_regfile.sv
module dct8_regfile #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[gi] <= '0;
            end else if (we && waddr == AW'(gi)) begin
                mem[gi] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/dct8_coef_rom.sv
module dct8_coef_rom
    import dct8_pkg::*;
(
    input  rom_addr_t                 addr,
    output logic signed [COEF_W-1:0]  coef
);
    logic signed [COEF_W-1:0] rom_tbl [ROM_DEPTH];

    for (genvar gi = 0; gi < ROM_DEPTH; gi++) begin : g_rom
        localparam logic [ROM_AW-1:0] A = ROM_AW'(gi);
        assign rom_tbl[gi] = coef_value(A[ROM_AW-1],
                                        A[2*IDX_W-1:IDX_W],
                                        A[IDX_W-1:0]);
    end

    assign coef = rom_tbl[addr];

endmodule

// File: rtl/dct8_mac.sv
module dct8_mac #(
    parameter int DW = 8,
    parameter int CW = 8,
    parameter int AW = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 first,
    input  logic signed [DW-1:0] sample,
    input  logic signed [CW-1:0] coef,
    output logic signed [AW-1:0] acc_next
);
    localparam int PW = DW + CW;

    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] prod_ext;
    logic signed [AW-1:0] base;

    assign prod     = sample * coef;
    assign prod_ext = $signed({{(AW-PW){prod[PW-1]}}, prod});

    always_comb begin
        base     = first ? '0 : acc_q;
        acc_next = base + prod_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (run) begin
            acc_q <= acc_next;
        end
    end

endmodule

// File: rtl/dct8_ctrl.sv
module dct8_ctrl
    import dct8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             enable,
    input  logic             idct,
    output phase_e           phase,
    output mode_e            mode_q,
    output logic             ld_we,
    output logic [IDX_W-1:0] io_idx,
    output mac_ctl_t         mac,
    output logic             ready
);
    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] k_q;
    logic [IDX_W-1:0] n_q;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NPT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            mode_q <= MODE_FWD;
            cnt_q  <= '0;
            k_q    <= '0;
            n_q    <= '0;
            ready  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase  <= PH_LOAD;
                        mode_q <= mode_e'(idct);
                        cnt_q  <= '0;
                    end
                end
                PH_LOAD: begin
                    if (enable) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST) begin
                            phase <= PH_MAC;
                            k_q   <= '0;
                            n_q   <= '0;
                        end
                    end
                end
                PH_MAC: begin
                    n_q <= n_q + 1'b1;
                    if (n_q == LAST) begin
                        k_q <= k_q + 1'b1;
                        if (k_q == LAST) begin
                            phase <= PH_UNLOAD;
                            ready <= 1'b1;
                            cnt_q <= '0;
                        end
                    end
                end
                PH_UNLOAD: begin
                    if (enable) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST) begin
                            phase <= PH_IDLE;
                            ready <= 1'b0;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ld_we     = (phase == PH_LOAD) && enable;
        io_idx    = cnt_q;
        mac.run   = (phase == PH_MAC);
        mac.first = (n_q == '0);
        mac.last  = (phase == PH_MAC) && (n_q == LAST);
        mac.out_i = k_q;
        mac.sum_i = n_q;
    end

endmodule

// File: rtl/dct8_engine.sv
module dct8_engine
    import dct8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              start,
    input  logic              idct,
    input  logic [DATA_W-1:0] x,
    output logic [DATA_W-1:0] y,
    output logic              ready
);
    phase_e                   phase;
    mode_e                    mode_q;
    logic                     ld_we;
    logic [IDX_W-1:0]         io_idx;
    mac_ctl_t                 mac;
    logic [DATA_W-1:0]        smp;
    logic signed [COEF_W-1:0] coef;
    logic signed [ACC_W-1:0]  acc_next;
    logic [DATA_W-1:0]        res_w;
    logic [DATA_W-1:0]        res_r;
    rom_addr_t                raddr;

    dct8_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .enable (enable),
        .idct   (idct),
        .phase  (phase),
        .mode_q (mode_q),
        .ld_we  (ld_we),
        .io_idx (io_idx),
        .mac    (mac),
        .ready  (ready)
    );

    dct8_regfile #(.DEPTH(NPT), .W(DATA_W)) u_samples (
        .clk   (clk),
        .rst   (rst),
        .we    (ld_we),
        .waddr (io_idx),
        .wdata (x),
        .raddr (mac.sum_i),
        .rdata (smp)
    );

    assign raddr = '{mode: mode_q, out_i: mac.out_i, sum_i: mac.sum_i};

    dct8_coef_rom u_rom (
        .addr (raddr),
        .coef (coef)
    );

    dct8_mac #(.DW(DATA_W), .CW(COEF_W), .AW(ACC_W)) u_mac (
        .clk      (clk),
        .rst      (rst),
        .run      (mac.run),
        .first    (mac.first),
        .sample   ($signed(smp)),
        .coef     (coef),
        .acc_next (acc_next)
    );

    assign res_w = sat_round(acc_next);

    dct8_regfile #(.DEPTH(NPT), .W(DATA_W)) u_results (
        .clk   (clk),
        .rst   (rst),
        .we    (mac.last),
        .waddr (mac.out_i),
        .wdata (res_w),
        .raddr (io_idx),
        .rdata (res_r)
    );

    assign y = ready ? res_r : '0;

endmodule

// File: rtl/dct8_engine_chk.sv
module dct8_engine_chk
    import dct8_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              enable,
    input logic              ready,
    input logic [DATA_W-1:0] y,
    input phase_e            phase
);
    logic [7:0] mac_run;
    logic       rst_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst || phase != PH_MAC) mac_run <= '0;
        else                        mac_run <= mac_run + 1'b1;
    end

    // R1: the cycle after reset shows an idle engine
    always @(posedge clk) begin
        if (rst_q) begin
            p_reset_idle_r1: assert (!ready && y == '0 && phase == PH_IDLE)
                else $error("reset did not leave engine idle");
        end
    end

    p_start_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MAC && start) |=> (phase == PH_MAC || phase == PH_UNLOAD));

    p_ready_latency_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (mac_run == 8'(MAC_STEPS)));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (ready && !enable) |=> (ready && $stable(y)));

    p_ready_fall_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(enable));

    p_y_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (y == '0));

endmodule

bind dct8_engine dct8_engine_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .enable (enable),
    .ready  (ready),
    .y      (y),
    .phase  (phase)
);

// File: tb/dct8_engine_tb_top.sv
module dct8_engine_tb_top;

    localparam real PI = 3.14159265358979;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       idct = 1'b0;
    logic       en_drv = 1'b0;
    logic       en_mon = 1'b0;
    logic [7:0] x = '0;
    logic [7:0] y;
    logic       ready;
    logic       enable;

    assign enable = en_drv | en_mon;

    always #2 clk = ~clk;

    dct8_engine dut_i (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .start  (start),
        .idct   (idct),
        .x      (x),
        .y      (y),
        .ready  (ready)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q[$];
    int blocks_done = 0;
    bit stall_next = 0;
    int unsigned seed = 32'h1234_5678;

    task automatic check(input string req, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // R6: reference weights from the cosine formula
    function automatic int ref_coef(input int f, input int p);
        real c;
        c = (f == 0) ? 1.0 / $sqrt(2.0) : 1.0;
        return int'(64.0 * c * $cos((2 * p + 1) * f * PI / 16.0));
    endfunction

    // R4 R5 R7: reference result
    function automatic int ref_out(input bit inv, input int s[8], input int idx);
        int acc;
        int r;
        acc = 0;
        for (int j = 0; j < 8; j++)
            acc += s[j] * (inv ? ref_coef(j, idx) : ref_coef(idx, j));
        r = (acc + 64) >>> 7;
        if (r > 127)  r = 127;
        if (r < -128) r = -128;
        return r;
    endfunction

    function automatic int rnd_sample();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'hff) - 128;
    endfunction

    // Driver: opens a block, loads samples, pushes expected results
    task automatic run_block(input bit inv, input int s[8], input bit gap,
                             input bit misuse, input bit stall, input bit timed);
        int target;
        int c;
        @(negedge clk);
        stall_next = stall;
        start = 1'b1;
        idct  = inv;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (gap && i == 3) begin
                en_drv = 1'b0;
                x = 8'h7f;
                @(negedge clk);
                @(negedge clk);
            end
            en_drv = 1'b1;
            x = s[i][7:0];
            @(negedge clk);
        end
        en_drv = 1'b0;
        x = 8'h55;
        for (int i = 0; i < 8; i++) exp_q.push_back(ref_out(inv, s, i));
        if (misuse) begin
            // R2 R10: start pulse and direction flip while busy
            repeat (5) @(negedge clk);
            start = 1'b1;
            idct  = ~inv;
            @(negedge clk);
            start = 1'b0;
        end
        if (timed) begin
            c = 0;
            while (!ready && c < 200) begin
                @(negedge clk);
                c++;
            end
            check("R8 ready latency", c, 64);
        end
        target = blocks_done + 1;
        wait (blocks_done == target);
        idct = 1'b0;
    endtask

    // Monitor: drains results when ready and compares with the queue
    initial begin
        forever begin
            @(negedge clk);
            if (ready) begin
                for (int i = 0; i < 8; i++) begin
                    if (exp_q.size() == 0) begin
                        check("R2 unexpected result", 1, 0);
                        break;
                    end
                    if (stall_next && i == 4) begin
                        en_mon = 1'b0;
                        repeat (3) begin
                            @(negedge clk);
                            check("R9 ready held on stall", int'(ready), 1);
                            check("R9 y held on stall", int'($signed(y)), exp_q[0]);
                        end
                    end
                    check("R4/R5 result value", int'($signed(y)), exp_q.pop_front());
                    en_mon = 1'b1;
                    @(negedge clk);
                end
                en_mon = 1'b0;
                check("R9 ready low after drain", int'(ready), 0);
                check("R11 y zero when not ready", int'(y), 0);
                blocks_done++;
            end
        end
    end

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int s[8];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready low after reset", int'(ready), 0);
        check("R11 y zero after reset", int'(y), 0);

        // R6: coefficient spot values
        check("R6 dc weight", ref_coef(0, 3), 45);
        check("R6 first ac weight", ref_coef(1, 0), 63);

        foreach (s[i]) s[i] = 0;
        run_block(1'b0, s, 1'b0, 1'b0, 1'b0, 1'b1);          // R4 zeros, R8 timing
        foreach (s[i]) s[i] = 100;
        run_block(1'b0, s, 1'b0, 1'b0, 1'b0, 1'b0);          // R7 positive clamp
        foreach (s[i]) s[i] = i * 10 - 35;
        run_block(1'b0, s, 1'b1, 1'b0, 1'b0, 1'b0);          // R3 load with gap
        foreach (s[i]) s[i] = (i % 2) ? -50 : 50;
        run_block(1'b0, s, 1'b0, 1'b0, 1'b0, 1'b0);          // R4 high frequency
        foreach (s[i]) s[i] = -128;
        run_block(1'b0, s, 1'b0, 1'b0, 1'b0, 1'b0);          // R7 negative clamp
        foreach (s[i]) s[i] = 0;
        s[0] = 127;
        run_block(1'b1, s, 1'b0, 1'b0, 1'b0, 1'b0);          // R5 inverse of dc
        foreach (s[i]) s[i] = 0;
        s[3] = 90;
        run_block(1'b0, s, 1'b0, 1'b0, 1'b0, 1'b0);          // R4 impulse
        foreach (s[i]) s[i] = 12 * i - 40;
        run_block(1'b1, s, 1'b0, 1'b0, 1'b1, 1'b0);          // R5 inverse, R9 stall
        foreach (s[i]) s[i] = 20 + 5 * i;
        run_block(1'b0, s, 1'b0, 1'b1, 1'b0, 1'b0);          // R2 R10 misuse
        for (int b = 0; b < 6; b++) begin
            foreach (s[i]) s[i] = rnd_sample();
            run_block(b[0], s, b[1], 1'b0, b == 2, 1'b0);
        end

        // R1: reset part-way through computation
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            en_drv = 1'b1;
            x = 8'd60;
            @(negedge clk);
        end
        en_drv = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 ready low after mid-block reset", int'(ready), 0);
        begin
            int seen;
            seen = 0;
            repeat (80) begin
                @(negedge clk);
                if (ready) seen++;
            end
            check("R1 no results after aborted block", seen, 0);
        end

        foreach (s[i]) s[i] = 70 - 15 * i;
        run_block(1'b1, s, 1'b0, 1'b0, 1'b0, 1'b1);          // R1 recovery, R8

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule